// File: doc/BRIEF.md
# Paced Double-Buffer Sample Capture

This block sets the pace of an external sampling converter for continuous audio capture and stores what comes back. A down-counter driven by the system clock issues a one-cycle conversion request every `period_cfg` cycles. For a 48 kHz stream on a 96 MHz clock, for example, `period_cfg` is 2000. Software never starts a conversion. Each counter wrap reloads the counter, so the spacing of the requests does not drift.

Each 12-bit result that comes back is held for one cycle. It is then written as a 16-bit half-word into a ring of 2N entries, shifted left so that it fills the upper bits of a Q15 word. Two notifications tell the consumer which half of the ring is ready to read: a one-cycle pulse when entry N-1 is written, and another when entry 2N-1 is written. Writing then continues at entry 0 without stopping.

A sticky overrun flag reports two faults: a request issued while the previous one is still unanswered, and a result that arrives while the previous result is still waiting to be written. A write-one-to-clear pulse clears the flag. Dropping the run control stops the requests, discards results and sends the write position back to entry 0.

Top module: `audio_capture_pacer`

## Requirements
- R1: After reset, `conv_start`, `mem_we`, `half_evt`, `full_evt` and `overrun` are all 0.
- R2: While `run` is 1, `conv_start` is a one-cycle pulse. The first pulse comes in the cycle after `run` is first sampled high, and later pulses are exactly `period_cfg` cycles apart (valid for `period_cfg` of 2 or more).
- R3: `period_cfg` is read only when a request is issued. A new value set mid-interval leaves the current interval at its old length and applies from the next interval on.
- R4: The written word is `{conv_data, 4'b0000}`: the result sits in bits [15:4] and bits [3:0] are zero. This covers 0x0000 up to 0xFFF0.
- R5: An accepted result is written (`mem_we` high) in the cycle after `conv_valid`. The k-th write after a start goes to entry k mod 2N.
- R6: `half_evt` is high for exactly one cycle, in the cycle after entry N-1 is written. `full_evt` behaves the same way for entry 2N-1. Each fires once per lap of the ring.
- R7: `overrun` sets when a request is issued while the previous request is still unanswered and no result arrives in that same cycle.
- R8: `overrun` sets when `conv_valid` arrives while an earlier result is still waiting to be written. That second result is discarded and causes no write.
- R9: `overrun` stays set until a cycle with `overrun_clr` high and no new fault, and then reads 0.
- R10: While `run` is 0, no requests are issued and results are discarded. The first write after `run` rises again goes to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Capture enable; low stops pacing and rewinds the ring |
| period_cfg | input | 16 | Clock cycles per sample period |
| overrun_clr | input | 1 | Write-one-to-clear for the overrun flag |
| conv_start | output | 1 | One-cycle conversion request to the converter |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result |
| mem_we | output | 1 | Half-word write enable |
| mem_addr | output | 4 | Ring entry index (default N = 8) |
| mem_wdata | output | 16 | Left-justified sample word |
| half_evt | output | 1 | Lower half of the ring filled |
| full_evt | output | 1 | Upper half of the ring filled |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions rely on three conditions. `period_cfg` is at least 2, so two requests are never adjacent. N is at least 2, so the two notifications never fall in adjacent cycles. `conv_valid` is a pulse that the converter raises only after a request.

The bench converter model returns each result two cycles after its request, at periods of 5 cycles or more. Only the two overrun scenarios break this rule on purpose: one withholds a result, the other sends two results back to back. Changes to `period_cfg` are made only while the counter is running and always stay at 2 or above.

// File: rtl/cap_pkg.sv
package cap_pkg;
    // default converter resolution and stored word width
    localparam int unsigned CONV_BITS_DEF = 12;
    localparam int unsigned WORD_BITS_DEF = 16;

    // which ring boundary a completed write crossed
    typedef enum logic [1:0] {
        BND_NONE = 2'd0,
        BND_HALF = 2'd1,
        BND_FULL = 2'd2
    } ring_bnd_e;
endpackage

// File: rtl/cap_period_timer.sv
module cap_period_timer #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period_cfg,
    output logic             strobe
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             strb;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.strb = 1'b0;
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == '0) begin
            // terminal count: issue request, reload from the setting
            tmr_d.strb = 1'b1;
            tmr_d.cnt  = period_cfg - PER_W'(1);
        end else begin
            tmr_d.cnt = tmr_q.cnt - PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign strobe = tmr_q.strb;

    // requests never fall in adjacent cycles (period of 2 or more)
    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // a stopped timer issues nothing
    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !strobe);
endmodule

// File: rtl/cap_conv_tracker.sv
module cap_conv_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic strobe,
    input  logic conv_valid,
    input  logic hold_busy,
    input  logic overrun_clr,
    output logic pending,
    output logic overrun
);
    typedef struct packed {
        logic pend;
        logic ovr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic trig_fault;
    logic data_fault;

    always_comb begin
        trk_d      = trk_q;
        trig_fault = run && strobe && trk_q.pend && !conv_valid;
        data_fault = run && conv_valid && hold_busy;

        if (!run)            trk_d.pend = 1'b0;
        else if (strobe)     trk_d.pend = 1'b1;
        else if (conv_valid) trk_d.pend = 1'b0;

        if (trig_fault || data_fault) trk_d.ovr = 1'b1;
        else if (overrun_clr)         trk_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pending = trk_q.pend;
    assign overrun = trk_q.ovr;

    // flag holds while no clear is requested
    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !overrun_clr |=> overrun);

    // a stop abandons any outstanding request
    assert_pend_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pending);

    // a request met by an outstanding one raises the flag
    assert_trig_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run && strobe && pending && !conv_valid |=> overrun);
endmodule

// File: rtl/cap_ring_writer.sv
module cap_ring_writer
    import cap_pkg::*;
#(
    parameter int unsigned SMP_W  = 12,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned HALF_N = 8,
    localparam int unsigned DEPTH = 2 * HALF_N,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PAD_W = WORD_W - SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              conv_valid,
    input  logic [SMP_W-1:0]  conv_data,
    output logic              hold_busy,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              half_evt,
    output logic              full_evt
);
    localparam logic [AW-1:0] MID_IDX  = AW'(HALF_N - 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic             hold;
        logic [SMP_W-1:0] data;
        logic [AW-1:0]    ptr;
        ring_bnd_e        bnd;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d     = wr_q;
        wr_d.bnd = BND_NONE;

        // held sample is written this cycle; advance the ring
        if (wr_q.hold) begin
            wr_d.hold = 1'b0;
            if (wr_q.ptr == MID_IDX)  wr_d.bnd = BND_HALF;
            if (wr_q.ptr == LAST_IDX) wr_d.bnd = BND_FULL;
            wr_d.ptr = (wr_q.ptr == LAST_IDX) ? '0 : wr_q.ptr + AW'(1);
        end

        // accept a new result only into an empty holding stage
        if (run && conv_valid && !wr_q.hold) begin
            wr_d.hold = 1'b1;
            wr_d.data = conv_data;
        end

        if (!run) begin
            wr_d.hold = 1'b0;
            wr_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '{hold: 1'b0, data: '0, ptr: '0, bnd: BND_NONE};
        else        wr_q <= wr_d;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign mem_wdata = {wr_q.data, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign mem_wdata = wr_q.data[SMP_W-1 -: WORD_W];
        end
    endgenerate

    assign hold_busy = wr_q.hold;
    assign mem_we    = wr_q.hold;
    assign mem_addr  = wr_q.ptr;
    assign half_evt  = (wr_q.bnd == BND_HALF);
    assign full_evt  = (wr_q.bnd == BND_FULL);

    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr <= LAST_IDX);

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_addr == LAST_IDX |=> mem_addr == '0);

    assert_half_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |-> $past(mem_we) && $past(mem_addr) == MID_IDX);

    assert_full_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |-> $past(mem_we) && $past(mem_addr) == LAST_IDX);

    assert_evt_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (half_evt || full_evt) |=> !(half_evt || full_evt));
endmodule

// File: rtl/audio_capture_pacer.sv
module audio_capture_pacer
    import cap_pkg::*;
#(
    parameter int unsigned SMP_W  = CONV_BITS_DEF,
    parameter int unsigned WORD_W = WORD_BITS_DEF,
    parameter int unsigned HALF_N = 8,
    parameter int unsigned PER_W  = 16,
    localparam int unsigned AW    = $clog2(2 * HALF_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PER_W-1:0]  period_cfg,
    input  logic              overrun_clr,
    output logic              conv_start,
    input  logic              conv_valid,
    input  logic [SMP_W-1:0]  conv_data,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              half_evt,
    output logic              full_evt,
    output logic              overrun
);
    logic strobe;
    logic hold_busy;
    logic pending;

    cap_period_timer #(.PER_W(PER_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .period_cfg (period_cfg),
        .strobe     (strobe)
    );

    cap_conv_tracker i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .strobe      (strobe),
        .conv_valid  (conv_valid),
        .hold_busy   (hold_busy),
        .overrun_clr (overrun_clr),
        .pending     (pending),
        .overrun     (overrun)
    );

    cap_ring_writer #(
        .SMP_W  (SMP_W),
        .WORD_W (WORD_W),
        .HALF_N (HALF_N)
    ) i_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .hold_busy  (hold_busy),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .half_evt   (half_evt),
        .full_evt   (full_evt)
    );

    assign conv_start = strobe;

    // the written word carries the result captured on the previous edge
    assert_data_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[WORD_W-1 -: SMP_W] == $past(conv_data));

    // a result landing on a full holding stage raises the flag
    assert_data_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run && conv_valid && mem_we |=> overrun);

    assert_evt_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(half_evt && full_evt));
endmodule

// File: tb/test_audio_capture_pacer.sv
module test_audio_capture_pacer;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int DEPTH = 2 * N;
    localparam int AW    = $clog2(DEPTH);
    localparam int LAT   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [15:0]   period_cfg = 16'd6;
    logic          overrun_clr = 1'b0;
    logic          conv_start;
    logic          conv_valid;
    logic [11:0]   conv_data;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          half_evt, full_evt, overrun;

    // converter model: automatic or hand-driven
    logic          auto_on = 1'b0;
    logic          auto_v = 1'b0;
    logic [11:0]   auto_d = '0;
    logic          man_v = 1'b0;
    logic [11:0]   man_d = '0;
    logic [11:0]   auto_val = 12'hFE0;
    int            lat_cnt = 0;
    logic [11:0]   sent_log [0:255];
    int            sent_n = 0;

    assign conv_valid = auto_on ? auto_v : man_v;
    assign conv_data  = auto_on ? auto_d : man_d;

    // memory model and logs
    logic [15:0]   mem [0:DEPTH-1];
    int            addr_log [0:255];
    int            wr_count = 0;
    int            cyc = 0;
    int            half_pos [0:15];
    int            full_pos [0:15];
    int            half_n = 0;
    int            full_n = 0;
    logic          prev_evt = 1'b0;
    int            dbl_evt = 0;

    int n_chk = 0;
    int n_fail = 0;

    audio_capture_pacer #(.HALF_N(N)) i_audio_capture_pacer (
        .clk(clk), .rst_n(rst_n), .run(run), .period_cfg(period_cfg),
        .overrun_clr(overrun_clr), .conv_start(conv_start),
        .conv_valid(conv_valid), .conv_data(conv_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .half_evt(half_evt),
        .full_evt(full_evt), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            addr_log[wr_count % 256] = int'(mem_addr);
            wr_count = wr_count + 1;
        end
    end

    always @(negedge clk) begin
        if (half_evt) begin half_pos[half_n % 16] = wr_count; half_n = half_n + 1; end
        if (full_evt) begin full_pos[full_n % 16] = wr_count; full_n = full_n + 1; end
        if ((half_evt || full_evt) && prev_evt) dbl_evt = dbl_evt + 1;
        prev_evt = half_evt || full_evt;
    end

    always @(negedge clk) begin
        auto_v = 1'b0;
        if (auto_on) begin
            if (conv_start) lat_cnt = LAT;
            else if (lat_cnt > 0) begin
                if (lat_cnt == 1) begin
                    auto_v = 1'b1;
                    auto_d = auto_val;
                    sent_log[sent_n % 256] = auto_val;
                    sent_n = sent_n + 1;
                    auto_val = auto_val + 12'h1A5;
                end
                lat_cnt = lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_strobe(output int at);
        at = -1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (conv_start) begin at = cyc; break; end
        end
    endtask

    task automatic wait_writes(input int target);
        for (int i = 0; i < 5000 && wr_count < target; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!conv_start && !mem_we, "R1", "start/we after reset", {conv_start, mem_we}, 0);
        chk(!half_evt && !full_evt, "R1", "events after reset", {half_evt, full_evt}, 0);
        chk(!overrun, "R1", "overrun after reset", overrun, 0);
    endtask

    task automatic t_spacing();
        int t0, t1, t2, t3, t4;
        int w_before;
        auto_on = 1'b1;
        period_cfg = 16'd6;
        @(negedge clk) run = 1'b1;
        @(negedge clk);
        chk(conv_start, "R2", "first request one cycle after run", conv_start, 1);
        t0 = cyc;
        wait_strobe(t1);
        wait_strobe(t2);
        chk(t1 - t0 == 6, "R2", "gap 1", t1 - t0, 6);
        chk(t2 - t1 == 6, "R2", "gap 2", t2 - t1, 6);
        // change mid-interval: current interval keeps the old length
        @(negedge clk) period_cfg = 16'd11;
        wait_strobe(t3);
        wait_strobe(t4);
        chk(t3 - t2 == 6, "R3", "interval after change", t3 - t2, 6);
        chk(t4 - t3 == 11, "R3", "next interval", t4 - t3, 11);
        chk(!overrun, "R7", "no overrun with timely results", overrun, 0);
        // stopping: no requests, no writes
        @(negedge clk) run = 1'b0;
        cycles(3);
        w_before = wr_count;
        t0 = 0;
        for (int i = 0; i < 25; i++) begin @(negedge clk); if (conv_start) t0++; end
        chk(t0 == 0, "R10", "requests while stopped", t0, 0);
        chk(wr_count == w_before, "R10", "writes while stopped", wr_count, w_before);
    endtask

    task automatic t_fill();
        int wb, sb, hb, fb, bad, k;
        period_cfg = 16'd5;
        cycles(8);
        wb = wr_count; sb = sent_n; hb = half_n; fb = full_n;
        @(negedge clk) run = 1'b1;
        wait_writes(wb + 2 * DEPTH + 3);
        cycles(2);
        @(negedge clk) run = 1'b0;
        cycles(6);
        bad = 0;
        for (int j = 0; j < 2 * DEPTH + 3; j++)
            if (addr_log[(wb + j) % 256] != j % DEPTH) bad++;
        chk(bad == 0, "R5", "circular entry order", bad, 0);
        bad = 0;
        for (int j = 0; j < DEPTH; j++) begin
            k = 2 * DEPTH + 3 - DEPTH + j;
            if (mem[k % DEPTH] != {sent_log[(sb + k) % 256], 4'h0}) bad++;
        end
        chk(bad == 0, "R4", "left-justified ring contents", bad, 0);
        chk(mem[0][3:0] == 4'h0 && mem[1][3:0] == 4'h0, "R4", "low nibble", mem[0], 0);
        chk(mem[(2 * DEPTH) % DEPTH] == {sent_log[(sb + 2 * DEPTH) % 256], 4'h0},
            "R4", "value near full scale", mem[0], {sent_log[(sb + 2 * DEPTH) % 256], 4'h0});
        chk(half_n - hb == 2, "R6", "half events over two laps", half_n - hb, 2);
        chk(full_n - fb == 2, "R6", "full events over two laps", full_n - fb, 2);
        chk(half_pos[hb % 16] - wb == N, "R6", "half position", half_pos[hb % 16] - wb, N);
        chk(full_pos[fb % 16] - wb == DEPTH, "R6", "full position", full_pos[fb % 16] - wb, DEPTH);
        chk(half_pos[(hb + 1) % 16] - wb == DEPTH + N, "R6", "second half position",
            half_pos[(hb + 1) % 16] - wb, DEPTH + N);
        chk(dbl_evt == 0, "R6", "event wider than one cycle", dbl_evt, 0);
        chk(!overrun, "R8", "no overrun in steady capture", overrun, 0);
    endtask

    task automatic t_restart();
        int wb, t;
        cycles(8);
        wb = wr_count;
        @(negedge clk) run = 1'b1;
        wait_writes(wb + 3);
        @(negedge clk) run = 1'b0;
        cycles(8);
        wb = wr_count;
        @(negedge clk) run = 1'b1;
        wait_writes(wb + 1);
        chk(addr_log[wb % 256] == 0, "R10", "first entry after restart", addr_log[wb % 256], 0);
        @(negedge clk) run = 1'b0;
        cycles(8);
        t = 0;
        chk(t == 0 && !overrun, "R10", "restart left no fault", overrun, 0);
    endtask

    task automatic t_trig_overrun();
        int t;
        auto_on = 1'b0;
        period_cfg = 16'd6;
        @(negedge clk) run = 1'b1;
        wait_strobe(t);
        chk(!overrun, "R7", "no fault after first request", overrun, 0);
        wait_strobe(t);
        chk(!overrun, "R7", "flag not yet set in request cycle", overrun, 0);
        @(negedge clk);
        chk(overrun, "R7", "request while unanswered", overrun, 1);
        @(negedge clk) run = 1'b0;
        cycles(10);
        chk(overrun, "R9", "flag sticky", overrun, 1);
        @(negedge clk) overrun_clr = 1'b1;
        @(negedge clk) overrun_clr = 1'b0;
        chk(!overrun, "R9", "cleared by write-one", overrun, 0);
    endtask

    task automatic t_data_overrun();
        int t, wb;
        logic [15:0] keep1;
        keep1 = mem[1];
        period_cfg = 16'd30;
        @(negedge clk) run = 1'b1;
        wait_strobe(t);
        wb = wr_count;
        man_v = 1'b1; man_d = 12'h5A3;
        @(negedge clk) man_d = 12'h2C7;
        @(negedge clk) man_v = 1'b0;
        chk(overrun, "R8", "result onto held result", overrun, 1);
        cycles(3);
        chk(wr_count == wb + 1, "R8", "second result discarded", wr_count - wb, 1);
        chk(mem[0] == 16'h5A30, "R5", "first result at entry 0", mem[0], 16'h5A30);
        chk(mem[1] == keep1, "R8", "entry 1 untouched", mem[1], keep1);
        @(negedge clk) run = 1'b0;
        // result while stopped is ignored
        @(negedge clk) begin man_v = 1'b1; man_d = 12'h111; end
        @(negedge clk) man_v = 1'b0;
        wb = wr_count;
        cycles(3);
        chk(wr_count == wb && !mem_we, "R10", "result while stopped", wr_count - wb, 0);
        @(negedge clk) overrun_clr = 1'b1;
        @(negedge clk) overrun_clr = 1'b0;
        chk(!overrun, "R9", "cleared again", overrun, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_spacing();
        t_fill();
        t_restart();
        t_trig_overrun();
        t_data_overrun();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule